// File: doc/BRIEF.md
# SDRAM Command Issue Sequencer

This block takes one command word written by software and turns it into SDRAM control-pin activity for one or two devices. The pins are a chip select for each device, RAS_n, CAS_n, WE_n, CKE and the address bus. The block decodes the requested operation and the bank-target bits, and it drops any request that breaks a targeting rule. A request that is kept goes out on the pins, followed by the NOP spacing that the operation needs.

The block covers the controller's initialisation and power-state commands:

- clock start
- precharge-all
- a burst of 1 to 16 auto-refresh commands from a single write
- mode-register load
- self-refresh entry
- power-down entry
- return to normal operation

While a sequence runs, `busy_o` is high. A write that arrives during that time is discarded and sets a sticky error flag. Dropped requests leave no trace, because the pins and the busy flag stay as they were. The number of devices fitted is set at build time with `DUAL_BANK`.

Top module: `sdram_cmd_seq`

## Requirements
- R1: Command word layout, from bit 0 upward: op code [2:0], bank-2 target bit 3, bank-1 target bit 4, repeat field [8:5] and mode value [22:9]. After reset the outputs are: busy 0, error 0, clock enable out 0, CKE 0, both chip selects 1, RAS_n/CAS_n/WE_n 1, address 0.
- R2: Until an op-1 (clock start) request has been accepted, every other request is dropped. The clock start request sets `sdclk_en_o` and CKE to 1 and holds busy for exactly one cycle.
- R3: A request with both target bits clear is dropped. A request with op 7 is dropped.
- R4: With two devices fitted, an op-2 (precharge-all) or op-3 (auto-refresh) request is dropped unless both target bits are set. When both are set, both chip selects go low in the same cycle.
- R5: With one device fitted, a request that sets the bank-2 target bit is dropped, and `cs_n_o[1]` never goes low.
- R6: Every accepted command appears on the pins in the cycle after the write is sampled, with busy high in that same cycle. Precharge-all drives CS_n,RAS_n,CAS_n,WE_n = 0,0,1,0 with A10 = 1. Busy then lasts 1+T_RP cycles.
- R7: An op-3 request issues (repeat field + 1) auto-refresh commands, each driven as 0,0,0,1 with CKE high. Busy lasts (repeat + 1)·(1+T_RC) cycles.
- R8: Consecutive auto-refresh commands are separated by exactly T_RC NOP cycles (CS_n low, RAS_n/CAS_n/WE_n high).
- R9: An op-4 (load mode) request drives 0,0,0,0 with address = mode value for one cycle. Busy lasts 1+T_MRD cycles.
- R10: An op-5 (self-refresh) request drives the auto-refresh encoding with CKE low in the same cycle, and CKE stays low afterwards. A later op-0 (normal) request drives CKE high.
- R11: An op-6 (power-down) request drives CKE low during a NOP cycle, and CKE stays low afterwards. A later op-0 request drives CKE high.
- R12: A write received while busy does not change the running sequence and sets `err_o`. `err_o` stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_we_i | input | 1 | Command word write strobe |
| cmd_word_i | input | 5+NREF_W+MRD_W | Command word |
| busy_o | output | 1 | Sequence in progress |
| err_o | output | 1 | Sticky: write received while busy |
| sdclk_en_o | output | 1 | SDRAM clock output enable |
| cke_o | output | 1 | SDRAM clock enable pin |
| cs_n_o | output | 2 | Chip selects, bit 0 bank 1, bit 1 bank 2 |
| ras_n_o | output | 1 | Row strobe |
| cas_n_o | output | 1 | Column strobe |
| we_n_o | output | 1 | Write enable pin |
| addr_o | output | MRD_W | Address bus |

## Verification
Auto-refresh bursts are driven with repeat fields 0, 2 and 15. Together these separate an off-by-one in the repeat count from a wrong NOP gap, and the busy length catches a missing or extra trailing wait. Precharge-all and auto-refresh are sent with one target bit, the other target bit, both, and neither. Each of these is also sent before and after clock start, so that each drop rule is seen to act on its own. A load-mode request that targets one device shows that the both-device rule is limited to the two operations it names. The single-device build is run with bank-2 targets to show that the unused chip select never moves. A collision written mid-burst shows that the running sequence is unchanged while the error flag latches.

// File: rtl/sdram_cmd_pkg.sv
package sdram_cmd_pkg;
  localparam int OP_LSB   = 0;
  localparam int OP_W     = 3;
  localparam int TGT2_BIT = 3;
  localparam int TGT1_BIT = 4;
  localparam int NREF_LSB = 5;
  localparam int A10_BIT  = 10;

  typedef enum logic [OP_W-1:0] {
    OP_NORMAL = 3'd0,
    OP_CLK_ON = 3'd1,
    OP_PALL   = 3'd2,
    OP_AREF   = 3'd3,
    OP_LMR    = 3'd4,
    OP_SREF   = 3'd5,
    OP_PDOWN  = 3'd6,
    OP_RSVD   = 3'd7
  } sdr_op_e;

  typedef struct packed {
    logic ras_n;
    logic cas_n;
    logic we_n;
  } sdr_ctl_t;

  localparam sdr_ctl_t CTL_NOP  = '{ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
  localparam sdr_ctl_t CTL_PALL = '{ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
  localparam sdr_ctl_t CTL_AREF = '{ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
  localparam sdr_ctl_t CTL_LMR  = '{ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};
endpackage

// File: rtl/sdram_cmd_check.sv
module sdram_cmd_check
  import sdram_cmd_pkg::*;
#(
  parameter bit DUAL_BANK = 1'b1,
  parameter int NREF_W    = 4,
  parameter int MRD_W     = 14,
  localparam int WORD_W   = NREF_LSB + NREF_W + MRD_W
) (
  input  logic              cmd_we_i,
  input  logic [WORD_W-1:0] cmd_word_i,
  input  logic              clk_on_i,
  input  logic              busy_i,
  output logic              accept_o,
  output logic              collide_o,
  output sdr_op_e           op_o,
  output logic [1:0]        tgt_o,
  output logic [NREF_W-1:0] nref_o,
  output logic [MRD_W-1:0]  mrd_o
);
  logic bank_ok, legal;

  assign op_o   = sdr_op_e'(cmd_word_i[OP_LSB +: OP_W]);
  assign tgt_o  = {cmd_word_i[TGT2_BIT], cmd_word_i[TGT1_BIT]};
  assign nref_o = cmd_word_i[NREF_LSB +: NREF_W];
  assign mrd_o  = cmd_word_i[NREF_LSB+NREF_W +: MRD_W];

  generate
    if (DUAL_BANK) begin : g_dual
      // both devices must see precharge-all and refresh together
      assign bank_ok = !((op_o == OP_PALL || op_o == OP_AREF) && tgt_o != 2'b11);
    end else begin : g_single
      assign bank_ok = !tgt_o[1];
    end
  endgenerate

  assign legal = (tgt_o != 2'b00) && (op_o != OP_RSVD) && bank_ok &&
                 (clk_on_i || op_o == OP_CLK_ON);

  assign accept_o  = cmd_we_i && !busy_i && legal;
  assign collide_o = cmd_we_i && busy_i;
endmodule

// File: rtl/sdram_cmd_fsm.sv
module sdram_cmd_fsm
  import sdram_cmd_pkg::*;
#(
  parameter bit DUAL_BANK = 1'b1,
  parameter int NREF_W    = 4,
  parameter int MRD_W     = 14,
  parameter int T_RC      = 4,
  parameter int T_RP      = 2,
  parameter int T_MRD     = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  sdr_op_e           op_i,
  input  logic [1:0]        tgt_i,
  input  logic [NREF_W-1:0] nref_i,
  input  logic [MRD_W-1:0]  mrd_i,
  output logic              busy_o,
  output logic              clk_on_o,
  output logic              cke_o,
  output logic [1:0]        cs_n_o,
  output sdr_ctl_t          ctl_o,
  output logic [MRD_W-1:0]  addr_o
);
  localparam int GAP_A   = (T_RC > T_RP) ? T_RC : T_RP;
  localparam int GAP_MAX = (GAP_A > T_MRD) ? GAP_A : T_MRD;
  localparam int WAIT_W  = (GAP_MAX > 0) ? $clog2(GAP_MAX + 1) : 1;
  localparam logic [1:0] BANK_MASK = DUAL_BANK ? 2'b11 : 2'b01;

  logic              busy_q, clk_on_q, cke_q;
  logic [WAIT_W-1:0] wait_q;
  logic [NREF_W-1:0] rep_q;
  logic [1:0]        cs_n_q;
  sdr_ctl_t          ctl_q;
  logic [MRD_W-1:0]  addr_q;

  function automatic logic [WAIT_W-1:0] gap_of(sdr_op_e op);
    case (op)
      OP_PALL: return WAIT_W'(T_RP);
      OP_AREF: return WAIT_W'(T_RC);
      OP_LMR:  return WAIT_W'(T_MRD);
      default: return '0;
    endcase
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      clk_on_q <= 1'b0;
      cke_q    <= 1'b0;
      wait_q   <= '0;
      rep_q    <= '0;
      cs_n_q   <= 2'b11;
      ctl_q    <= CTL_NOP;
      addr_q   <= '0;
    end else if (!busy_q) begin
      cs_n_q <= 2'b11;
      ctl_q  <= CTL_NOP;
      addr_q <= '0;
      if (accept_i) begin
        busy_q <= 1'b1;
        cs_n_q <= ~(tgt_i & BANK_MASK);
        wait_q <= gap_of(op_i);
        rep_q  <= (op_i == OP_AREF) ? nref_i : '0;
        case (op_i)
          OP_CLK_ON: begin clk_on_q <= 1'b1; cke_q <= 1'b1; end
          OP_NORMAL: cke_q <= 1'b1;
          OP_PALL:   begin ctl_q <= CTL_PALL; addr_q[A10_BIT] <= 1'b1; end
          OP_AREF:   ctl_q <= CTL_AREF;
          OP_LMR:    begin ctl_q <= CTL_LMR; addr_q <= mrd_i; end
          OP_SREF:   begin ctl_q <= CTL_AREF; cke_q <= 1'b0; end
          OP_PDOWN:  cke_q <= 1'b0;
          default:   ;
        endcase
      end
    end else begin
      ctl_q  <= CTL_NOP;
      addr_q <= '0;
      if (wait_q != '0) begin
        wait_q <= wait_q - 1'b1;
      end else if (rep_q != '0) begin
        rep_q  <= rep_q - 1'b1;
        ctl_q  <= CTL_AREF;
        wait_q <= WAIT_W'(T_RC);
      end else begin
        busy_q <= 1'b0;
        cs_n_q <= 2'b11;
      end
    end
  end

  assign busy_o   = busy_q;
  assign clk_on_o = clk_on_q;
  assign cke_o    = cke_q;
  assign cs_n_o   = cs_n_q;
  assign ctl_o    = ctl_q;
  assign addr_o   = addr_q;

  // refresh spacing monitor
  logic              ar_now, ar_seen_q;
  logic [WAIT_W:0]   since_q;
  assign ar_now = (ctl_q == CTL_AREF) && cke_q && (cs_n_q != 2'b11);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ar_seen_q <= 1'b0;
      since_q   <= '0;
    end else if (ar_now) begin
      ar_seen_q <= 1'b1;
      since_q   <= '0;
    end else if (since_q <= (WAIT_W+1)'(T_RC)) begin
      since_q <= since_q + 1'b1;
    end
  end

  assert_aref_gap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ar_now && ar_seen_q) |-> (since_q >= (WAIT_W+1)'(T_RC)));

  assert_lmr_addr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_i && !busy_o && op_i == OP_LMR) |=> (ctl_o == CTL_LMR && addr_o == $past(mrd_i)));

  assert_sref_cke_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_i && !busy_o && op_i == OP_SREF) |=> (!cke_o && ctl_o == CTL_AREF));

  assert_accept_busy_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_i && !busy_o) |=> busy_o);
endmodule

// File: rtl/sdram_cmd_seq.sv
module sdram_cmd_seq
  import sdram_cmd_pkg::*;
#(
  parameter bit DUAL_BANK = 1'b1,
  parameter int NREF_W    = 4,
  parameter int MRD_W     = 14,
  parameter int T_RC      = 4,
  parameter int T_RP      = 2,
  parameter int T_MRD     = 2,
  localparam int WORD_W   = NREF_LSB + NREF_W + MRD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_we_i,
  input  logic [WORD_W-1:0] cmd_word_i,
  output logic              busy_o,
  output logic              err_o,
  output logic              sdclk_en_o,
  output logic              cke_o,
  output logic [1:0]        cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic [MRD_W-1:0]  addr_o
);
  logic              accept, collide, busy, clk_on;
  sdr_op_e           op;
  logic [1:0]        tgt;
  logic [NREF_W-1:0] nref;
  logic [MRD_W-1:0]  mrd;
  sdr_ctl_t          ctl;
  logic              err_q;

  sdram_cmd_check #(
    .DUAL_BANK(DUAL_BANK), .NREF_W(NREF_W), .MRD_W(MRD_W)
  ) u_check (
    .cmd_we_i  (cmd_we_i),
    .cmd_word_i(cmd_word_i),
    .clk_on_i  (clk_on),
    .busy_i    (busy),
    .accept_o  (accept),
    .collide_o (collide),
    .op_o      (op),
    .tgt_o     (tgt),
    .nref_o    (nref),
    .mrd_o     (mrd)
  );

  sdram_cmd_fsm #(
    .DUAL_BANK(DUAL_BANK), .NREF_W(NREF_W), .MRD_W(MRD_W),
    .T_RC(T_RC), .T_RP(T_RP), .T_MRD(T_MRD)
  ) u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .accept_i(accept),
    .op_i    (op),
    .tgt_i   (tgt),
    .nref_i  (nref),
    .mrd_i   (mrd),
    .busy_o  (busy),
    .clk_on_o(clk_on),
    .cke_o   (cke_o),
    .cs_n_o  (cs_n_o),
    .ctl_o   (ctl),
    .addr_o  (addr_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      err_q <= 1'b0;
    else if (collide) err_q <= 1'b1;
  end

  assign busy_o     = busy;
  assign err_o      = err_q;
  assign sdclk_en_o = clk_on;
  assign ras_n_o    = ctl.ras_n;
  assign cas_n_o    = ctl.cas_n;
  assign we_n_o     = ctl.we_n;

  assert_gate_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sdclk_en_o |-> (cs_n_o == 2'b11));

  assert_err_set_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_we_i && busy_o) |=> err_o);

  assert_err_sticky_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);

  generate
    if (DUAL_BANK) begin : g_chk_dual
      assert_pall_both_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ctl == CTL_PALL && cs_n_o != 2'b11) |-> (cs_n_o == 2'b00));
    end else begin : g_chk_single
      assert_unused_cs_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cs_n_o[1]);
    end
  endgenerate
endmodule

// File: tb/tb_sdram_cmd_seq.sv
`timescale 1ns/1ps
module tb_sdram_cmd_seq;
  localparam int NREF_W = 4;
  localparam int MRD_W  = 14;
  localparam int W      = 5 + NREF_W + MRD_W;
  localparam int T_RC   = 4;
  localparam int T_RP   = 2;
  localparam int T_MRD  = 2;
  localparam int OBS    = 100;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  always #10 clk_i = ~clk_i;

  logic         we0 = 1'b0, we1 = 1'b0;
  logic [W-1:0] wd0 = '0, wd1 = '0;
  logic busy0, err0, sck0, cke0, ras0, cas0, wen0;
  logic busy1, err1, sck1, cke1, ras1, cas1, wen1;
  logic [1:0] cs0, cs1;
  logic [MRD_W-1:0] ad0, ad1;

  sdram_cmd_seq #(.DUAL_BANK(1'b1), .NREF_W(NREF_W), .MRD_W(MRD_W),
                  .T_RC(T_RC), .T_RP(T_RP), .T_MRD(T_MRD)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .cmd_we_i(we0), .cmd_word_i(wd0),
    .busy_o(busy0), .err_o(err0), .sdclk_en_o(sck0), .cke_o(cke0),
    .cs_n_o(cs0), .ras_n_o(ras0), .cas_n_o(cas0), .we_n_o(wen0), .addr_o(ad0));

  sdram_cmd_seq #(.DUAL_BANK(1'b0), .NREF_W(NREF_W), .MRD_W(MRD_W),
                  .T_RC(T_RC), .T_RP(T_RP), .T_MRD(T_MRD)) dut_sb (
    .clk_i(clk_i), .rst_ni(rst_ni), .cmd_we_i(we1), .cmd_word_i(wd1),
    .busy_o(busy1), .err_o(err1), .sdclk_en_o(sck1), .cke_o(cke1),
    .cs_n_o(cs1), .ras_n_o(ras1), .cas_n_o(cas1), .we_n_o(wen1), .addr_o(ad1));

  int cur = 0;
  logic busy, err, sck, cke;
  logic [1:0] cs;
  logic [2:0] ctl;
  logic [MRD_W-1:0] ad;
  always_comb begin
    if (cur == 0) begin
      busy = busy0; err = err0; sck = sck0; cke = cke0; cs = cs0; ctl = {ras0, cas0, wen0}; ad = ad0;
    end else begin
      busy = busy1; err = err1; sck = sck1; cke = cke1; cs = cs1; ctl = {ras1, cas1, wen1}; ad = ad1;
    end
  end

  int tests = 0, fails = 0;
  bit done = 1'b0;

  int n_busy, n_ar, n_sr, n_pall, n_lmr, min_gap;
  logic [1:0] ar_cs, pall_cs, lmr_cs, cs_first;
  logic [2:0] ctl_first;
  logic cke_first, pall_a10, cs1_low;
  logic [MRD_W-1:0] lmr_addr;

  function automatic logic [W-1:0] mk(input int op, input bit t2, input bit t1,
                                      input int nref, input int mrd);
    return {MRD_W'(mrd), NREF_W'(nref), t1, t2, 3'(op)};
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic drv(input int s, input logic v, input logic [W-1:0] w);
    if (s == 0) begin we0 = v; wd0 = w; end
    else        begin we1 = v; wd1 = w; end
  endtask

  task automatic run(input int s, input logic [W-1:0] w, input int inj, input logic [W-1:0] w2);
    int last;
    cur = s;
    n_busy = 0; n_ar = 0; n_sr = 0; n_pall = 0; n_lmr = 0; min_gap = 1000;
    ar_cs = 2'b11; pall_cs = 2'b11; lmr_cs = 2'b11; pall_a10 = 1'b0; cs1_low = 1'b0;
    lmr_addr = '0; last = -1;
    @(negedge clk_i); drv(s, 1'b1, w);
    @(negedge clk_i); drv(s, 1'b0, '0);
    for (int k = 0; k < OBS; k++) begin
      if (k == inj) drv(s, 1'b1, w2);
      else if (k == inj + 1) drv(s, 1'b0, '0);
      if (k == 0) begin cs_first = cs; ctl_first = ctl; cke_first = cke; end
      if (busy) n_busy++;
      if (!cs[1]) cs1_low = 1'b1;
      if (cs != 2'b11 && ctl == 3'b001) begin
        if (cke) begin
          n_ar++;
          if (last >= 0 && (k - last) < min_gap) min_gap = k - last;
          last = k; ar_cs = cs;
        end else n_sr++;
      end
      if (cs != 2'b11 && ctl == 3'b010) begin n_pall++; pall_cs = cs; pall_a10 = ad[10]; end
      if (cs != 2'b11 && ctl == 3'b000) begin n_lmr++; lmr_cs = cs; lmr_addr = ad; end
      @(negedge clk_i);
    end
  endtask

  task automatic t_reset;
    @(negedge clk_i);
    cur = 0; #1;
    chk("R1", "busy", busy, 0); chk("R1", "err", err, 0); chk("R1", "sdclk", sck, 0);
    chk("R1", "cke", cke, 0);   chk("R1", "cs_n", cs, 3); chk("R1", "ctl", ctl, 7);
    chk("R1", "addr", ad, 0);
  endtask

  task automatic t_pre_clock;
    run(0, mk(2, 1, 1, 0, 0), -5, '0);
    chk("R2", "pall before clock start", n_pall, 0);
    chk("R2", "busy before clock start", n_busy, 0);
    run(0, mk(4, 1, 1, 0, 5), -5, '0);
    chk("R2", "lmr before clock start", n_lmr, 0);
  endtask

  task automatic t_clock_on;
    run(0, mk(1, 1, 1, 0, 0), -5, '0);
    chk("R2", "clock start busy", n_busy, 1);
    chk("R2", "sdclk_en", sck, 1);
    chk("R2", "cke", cke, 1);
  endtask

  task automatic t_no_target;
    run(0, mk(3, 0, 0, 0, 0), -5, '0);
    chk("R3", "no target refresh", n_ar, 0);
    chk("R3", "no target busy", n_busy, 0);
    run(0, mk(7, 1, 1, 0, 0), -5, '0);
    chk("R3", "reserved op busy", n_busy, 0);
    chk("R3", "reserved op cs", cs_first, 3);
  endtask

  task automatic t_dual_rule;
    run(0, mk(2, 0, 1, 0, 0), -5, '0);
    chk("R4", "pall bank1 only", n_pall + n_busy, 0);
    run(0, mk(3, 1, 0, 0, 0), -5, '0);
    chk("R4", "aref bank2 only", n_ar + n_busy, 0);
    run(0, mk(2, 1, 1, 0, 0), -5, '0);
    chk("R4", "pall both cs", pall_cs, 0);
    chk("R6", "pall count", n_pall, 1);
    chk("R6", "pall a10", pall_a10, 1);
    chk("R6", "pall first-cycle ctl", ctl_first, 3'b010);
    chk("R6", "pall busy", n_busy, 1 + T_RP);
  endtask

  task automatic t_aref;
    run(0, mk(3, 1, 1, 0, 0), -5, '0);
    chk("R7", "single refresh", n_ar, 1);
    chk("R7", "single refresh busy", n_busy, 1 + T_RC);
    chk("R4", "refresh cs both", ar_cs, 0);
    run(0, mk(3, 1, 1, 2, 0), -5, '0);
    chk("R7", "three refreshes", n_ar, 3);
    chk("R7", "three refresh busy", n_busy, 3 * (1 + T_RC));
    chk("R8", "refresh spacing", min_gap, T_RC + 1);
    run(0, mk(3, 1, 1, 15, 0), -5, '0);
    chk("R7", "sixteen refreshes", n_ar, 16);
    chk("R7", "sixteen refresh busy", n_busy, 16 * (1 + T_RC));
    chk("R8", "spacing long burst", min_gap, T_RC + 1);
  endtask

  task automatic t_lmr;
    run(0, mk(4, 0, 1, 0, 14'h2A5), -5, '0);
    chk("R9", "lmr count", n_lmr, 1);
    chk("R9", "lmr addr", lmr_addr, 14'h2A5);
    chk("R9", "lmr cs bank1", lmr_cs, 2'b10);
    chk("R9", "lmr busy", n_busy, 1 + T_MRD);
    run(0, mk(4, 1, 1, 0, 14'h3FFF), -5, '0);
    chk("R9", "lmr addr all ones", lmr_addr, 14'h3FFF);
  endtask

  task automatic t_sref;
    run(0, mk(5, 1, 1, 0, 0), -5, '0);
    chk("R10", "sref encoding cke low", n_sr, 1);
    chk("R10", "sref no normal refresh", n_ar, 0);
    chk("R10", "cke held low", cke, 0);
    run(0, mk(0, 1, 1, 0, 0), -5, '0);
    chk("R10", "normal raises cke", cke, 1);
    chk("R10", "normal busy", n_busy, 1);
  endtask

  task automatic t_pdown;
    run(0, mk(6, 1, 1, 0, 0), -5, '0);
    chk("R11", "pdown cke low", cke_first, 0);
    chk("R11", "pdown nop ctl", ctl_first, 3'b111);
    chk("R11", "pdown cs low", cs_first, 0);
    chk("R11", "pdown no command", n_ar + n_sr + n_pall + n_lmr, 0);
    chk("R11", "cke held low", cke, 0);
    run(0, mk(0, 1, 1, 0, 0), -5, '0);
    chk("R11", "normal raises cke", cke, 1);
  endtask

  task automatic t_collide;
    cur = 0; #1;
    chk("R12", "err before collision", err, 0);
    run(0, mk(3, 1, 1, 0, 0), 2, mk(2, 1, 1, 0, 0));
    chk("R12", "refresh unaffected", n_ar, 1);
    chk("R12", "late pall dropped", n_pall, 0);
    chk("R12", "busy unchanged", n_busy, 1 + T_RC);
    chk("R12", "err set", err, 1);
    run(0, mk(0, 1, 1, 0, 0), -5, '0);
    chk("R12", "err sticky", err, 1);
  endtask

  task automatic t_single;
    run(1, mk(1, 0, 1, 0, 0), -5, '0);
    chk("R2", "single clock start", sck, 1);
    run(1, mk(3, 1, 0, 0, 0), -5, '0);
    chk("R5", "bank2 target dropped", n_ar + n_busy, 0);
    run(1, mk(2, 1, 1, 0, 0), -5, '0);
    chk("R5", "both targets dropped", n_pall + n_busy, 0);
    run(1, mk(3, 0, 1, 1, 0), -5, '0);
    chk("R5", "bank1 refresh count", n_ar, 2);
    chk("R5", "unused cs never low", cs1_low, 0);
    chk("R8", "single spacing", min_gap, T_RC + 1);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_pre_clock();
    t_clock_on();
    t_no_target();
    t_dual_rule();
    t_aref();
    t_lmr();
    t_sref();
    t_pdown();
    t_collide();
    t_single();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      done = 1'b1;
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule